// File: doc/BRIEF.md
# Accumulator Multiply and Divide Unit

This unit performs unsigned 8-bit multiplication and division on the values of an accumulator and an auxiliary register. A one-cycle start strobe, together with an operation select, captures both operands. After a fixed latency of four machine cycles, the unit presents new values for both registers. At the same time it presents a carry flag and an overflow flag, and raises a one-cycle done strobe. The surrounding core writes these values back when it sees the strobe.

Multiplication places the low byte of the 16-bit product in the accumulator and the high byte in the auxiliary register. Division takes the dividend from the accumulator and the divisor from the auxiliary register. It returns the quotient in the accumulator and the remainder in the auxiliary register. Both results are built iteratively, a few bits per clock, so that the arithmetic fills the latency window. The unit also outputs the even-parity bit of the accumulator result.

Top module: `acc_muldiv_unit`

## Requirements
- R1: With the operation select at 0 (multiply), the result satisfies {aux_o, acc_o} == acc_i * aux_i, treating both operands as unsigned 8-bit values. acc_o holds the low byte and aux_o holds the high byte.
- R2: After a multiply, ov_o is 1 when the product is greater than 0xFF and 0 otherwise.
- R3: cy_o is 0 after every operation, both multiply and divide.
- R4: With the operation select at 1 (divide) and a nonzero divisor, acc_o is the quotient acc_i / aux_i and aux_o is the remainder acc_i % aux_i.
- R5: After a divide with a nonzero divisor, ov_o is 0.
- R6: After a divide by zero, ov_o is 1, acc_o equals the captured dividend and aux_o equals the captured divisor (0).
- R7: When a start is accepted at a clock edge, done_o is high for exactly one cycle, following the fourth clock edge after it. busy_o is high from the first edge through the fourth edge.
- R8: A start strobe that arrives while busy_o is high is ignored. It does not change the operands, the operation or the done timing.
- R9: par_o is the XOR of all bits of acc_o, so that acc_o together with par_o holds an even number of ones.
- R10: While reset is asserted, acc_o, aux_o, cy_o, ov_o, par_o, done_o and busy_o are all 0.
- R11: acc_o, aux_o, cy_o and ov_o change only at the edge that raises done_o. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| acc_i | input | 8 | Accumulator operand |
| aux_i | input | 8 | Auxiliary register operand |
| acc_o | output | 8 | New accumulator value |
| aux_o | output | 8 | New auxiliary register value |
| cy_o | output | 1 | Carry flag result |
| ov_o | output | 1 | Overflow flag result |
| par_o | output | 1 | Even parity of acc_o |
| done_o | output | 1 | One-cycle write-back strobe |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench sweeps every accumulator value against a spread of auxiliary values, always including 0 and 0xFF. This exercises the overflow boundary at a product of 0xFF versus 0x100 and the divide-by-zero path. Without this sweep, a design that dropped a partial-product carry or a restoring-step borrow would go unnoticed, and so would a design that wrote garbage on a zero divisor. On a regular share of the operations, a second start carrying altered operands and the opposite operation is applied while the unit is busy. This is done both at the first busy edge and at the last one. A design that reloaded on either strobe would return the wrong results or a late done. One cycle after each done strobe, the bench checks that the outputs are held and the strobe has dropped. This exposes a stretched pulse and outputs that drift between operations.

// File: rtl/amd_pkg.sv
package amd_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } amd_op_e;
endpackage

// File: rtl/amd_seq.sv
module amd_seq #(
  parameter int TOT  = 4,
  parameter int ITER = 4,
  localparam int CW  = $clog2(TOT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          step_o,
  output logic [CW-1:0] iter_o,
  output logic          last_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q & (cnt_q < CW'(ITER));
  assign last_o = busy_q & (cnt_q == CW'(TOT - 1));
  assign iter_o = cnt_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !last_o |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1)); // R8

  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CW'(TOT)); // R7
endmodule

// File: rtl/amd_mul.sv
module amd_mul #(
  parameter int W    = 8,
  parameter int BPC  = 2,
  parameter int IW   = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [IW-1:0]  iter_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] p_q;
  logic [W-1:0]   mc_q;
  logic [2*W-1:0] stg [BPC+1];

  assign stg[0] = p_q;

  for (genvar j = 0; j < BPC; j++) begin : g_bit
    logic         en;
    logic [W:0]   hi_sum;
    logic [2*W:0] wide;
    assign en     = (32'(iter_i) * BPC + j) < W;
    assign hi_sum = {1'b0, stg[j][2*W-1:W]} + (stg[j][0] ? {1'b0, mc_q} : '0);
    assign wide   = {hi_sum, stg[j][W-1:0]};
    assign stg[j+1] = en ? wide[2*W:1] : stg[j];
  end

  assign prod_o = step_i ? stg[BPC] : p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q  <= '0;
      mc_q <= '0;
    end else if (load_i) begin
      p_q  <= {{W{1'b0}}, b_i};
      mc_q <= a_i;
    end else if (step_i) begin
      p_q  <= stg[BPC];
    end
  end
endmodule

// File: rtl/amd_div.sv
module amd_div #(
  parameter int W   = 8,
  parameter int BPC = 2,
  parameter int IW  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [IW-1:0] iter_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  quo_o,
  output logic [W-1:0]  rem_o
);
  logic [W-1:0] r_q, q_q, d_q;
  logic [W-1:0] rs [BPC+1];
  logic [W-1:0] qs [BPC+1];

  assign rs[0] = r_q;
  assign qs[0] = q_q;

  for (genvar j = 0; j < BPC; j++) begin : g_bit
    logic       en, ge;
    logic [W:0] r2, diff;
    assign en   = (32'(iter_i) * BPC + j) < W;
    assign r2   = {rs[j], qs[j][W-1]};
    assign ge   = r2 >= {1'b0, d_q};
    assign diff = r2 - {1'b0, d_q};
    assign rs[j+1] = !en ? rs[j] : (ge ? diff[W-1:0] : r2[W-1:0]);
    assign qs[j+1] = !en ? qs[j] : {qs[j][W-2:0], ge};
  end

  assign quo_o = step_i ? qs[BPC] : q_q;
  assign rem_o = step_i ? rs[BPC] : r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
      q_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      r_q <= '0;
      q_q <= a_i;
      d_q <= b_i;
    end else if (step_i) begin
      r_q <= rs[BPC];
      q_q <= qs[BPC];
    end
  end
endmodule

// File: rtl/acc_muldiv_unit.sv
module acc_muldiv_unit #(
  parameter int W           = 8,
  parameter int LAT_MC      = 4,
  parameter int CLKS_PER_MC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] aux_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] aux_o,
  output logic         cy_o,
  output logic         ov_o,
  output logic         par_o,
  output logic         done_o,
  output logic         busy_o
);
  import amd_pkg::*;

  localparam int TOT  = LAT_MC * CLKS_PER_MC;
  localparam int BPC  = (W + TOT - 1) / TOT;
  localparam int ITER = (W + BPC - 1) / BPC;
  localparam int CW   = $clog2(TOT + 1);

  logic          load, step, last;
  logic [CW-1:0] iter;
  logic [2*W-1:0] prod;
  logic [W-1:0]  quo, rem;

  amd_op_e       op_q;
  logic [W-1:0]  a_q, b_q;
  logic          dz_q;
  logic [W-1:0]  acc_q, aux_q;
  logic          cy_q, ov_q, done_q;

  amd_seq #(.TOT(TOT), .ITER(ITER)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .busy_o (busy_o),
    .load_o (load),
    .step_o (step),
    .iter_o (iter),
    .last_o (last)
  );

  amd_mul #(.W(W), .BPC(BPC), .IW(CW)) u_mul (
    .clk_i, .rst_ni,
    .load_i (load), .step_i (step), .iter_i (iter),
    .a_i (acc_i), .b_i (aux_i),
    .prod_o (prod)
  );

  amd_div #(.W(W), .BPC(BPC), .IW(CW)) u_div (
    .clk_i, .rst_ni,
    .load_i (load), .step_i (step), .iter_i (iter),
    .a_i (acc_i), .b_i (aux_i),
    .quo_o (quo), .rem_o (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_MUL;
      a_q  <= '0;
      b_q  <= '0;
      dz_q <= 1'b0;
    end else if (load) begin
      op_q <= amd_op_e'(op_div_i);
      a_q  <= acc_i;
      b_q  <= aux_i;
      dz_q <= (aux_i == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      aux_q  <= '0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (last) begin
        cy_q <= 1'b0;
        if (op_q == OP_MUL) begin
          acc_q <= prod[W-1:0];
          aux_q <= prod[2*W-1:W];
          ov_q  <= |prod[2*W-1:W];
        end else if (dz_q) begin
          // divide by zero: registers keep their operands
          acc_q <= a_q;
          aux_q <= b_q;
          ov_q  <= 1'b1;
        end else begin
          acc_q <= quo;
          aux_q <= rem;
          ov_q  <= 1'b0;
        end
      end
    end
  end

  assign acc_o  = acc_q;
  assign aux_o  = aux_q;
  assign cy_o   = cy_q;
  assign ov_o   = ov_q;
  assign done_o = done_q;
  assign par_o  = ^acc_q;

  AST_MUL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_q == OP_MUL |-> {aux_o, acc_o} == {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}); // R1

  AST_MUL_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_q == OP_MUL |-> ov_o == (({{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}) > (2*W)'((1 << W) - 1))); // R2

  AST_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cy_o); // R3

  AST_DIV_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_q == OP_DIV && b_q != '0 |-> acc_o == a_q / b_q && aux_o == a_q % b_q && !ov_o); // R4 R5

  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_q == OP_DIV && b_q == '0 |-> ov_o && acc_o == a_q && aux_o == b_q); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(acc_o) && $stable(aux_o) && $stable(ov_o) && $stable(cy_o)); // R11
endmodule

// File: tb/tb_acc_muldiv_unit.sv
module tb_acc_muldiv_unit;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       op_div_i = 1'b0;
  logic [7:0] acc_i = '0;
  logic [7:0] aux_i = '0;
  logic [7:0] acc_o, aux_o;
  logic       cy_o, ov_o, par_o, done_o, busy_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  acc_muldiv_unit dut (
    .clk_i (clk), .rst_ni, .start_i, .op_div_i, .acc_i, .aux_i,
    .acc_o, .aux_o, .cy_o, .ov_o, .par_o, .done_o, .busy_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ign: 0 none, 1 extra start at first busy edge, 2 extra start at last busy edge
  task automatic do_op(input logic op, input logic [7:0] a, input logic [7:0] b, input int ign);
    logic [7:0] ea, eb;
    logic       eov;
    logic [15:0] p;
    if (!op) begin
      p = 16'(a) * 16'(b);
      ea = p[7:0]; eb = p[15:8]; eov = (p > 16'h00ff);
    end else if (b == 0) begin
      ea = a; eb = b; eov = 1'b1;
    end else begin
      ea = a / b; eb = a % b; eov = 1'b0;
    end
    start_i = 1'b1; op_div_i = op; acc_i = a; aux_i = b;
    @(negedge clk);
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    chk(done_o == 1'b0, "R7 done early", done_o, 0);
    if (ign == 1) begin
      start_i = 1'b1; op_div_i = ~op; acc_i = ~a; aux_i = ~b;
    end else start_i = 1'b0;
    for (int i = 2; i <= LAT; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R7 done early", done_o, 0);
      chk(busy_o == 1'b1, "R7 busy during op", busy_o, 1);
      if (i == LAT && ign == 2) begin
        start_i = 1'b1; op_div_i = ~op; acc_i = ~a; aux_i = ~b;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7 done at latency", done_o, 1);
    chk(busy_o == 1'b0, "R7 busy cleared", busy_o, 0);
    if (!op) begin
      chk(acc_o == ea, "R1 mul low byte", acc_o, ea);
      chk(aux_o == eb, "R1 mul high byte", aux_o, eb);
      chk(ov_o == eov, "R2 mul overflow", ov_o, eov);
    end else if (b == 0) begin
      chk(ov_o == 1'b1, "R6 div zero overflow", ov_o, 1);
      chk(acc_o == ea && aux_o == eb, "R6 div zero regs held", {acc_o, aux_o}, {ea, eb});
    end else begin
      chk(acc_o == ea, "R4 quotient", acc_o, ea);
      chk(aux_o == eb, "R4 remainder", aux_o, eb);
      chk(ov_o == 1'b0, "R5 div overflow clear", ov_o, 0);
    end
    chk(cy_o == 1'b0, "R3 carry clear", cy_o, 0);
    chk(par_o == ^ea, "R9 parity", par_o, ^ea);
    if (ign != 0) chk(acc_o == ea && aux_o == eb, "R8 ignored start", {acc_o, aux_o}, {ea, eb});
    @(negedge clk);
    chk(done_o == 1'b0, "R7 single pulse", done_o, 0);
    chk(busy_o == 1'b0, "R8 no restart", busy_o, 0);
    chk(acc_o == ea && aux_o == eb && ov_o == eov && !cy_o, "R11 outputs held",
        {acc_o, aux_o, 6'b0, ov_o, cy_o}, {ea, eb, 6'b0, eov, 1'b0});
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog act=hang exp=finish");
    summary();
  end

  initial begin
    #2;
    chk(acc_o == 0 && aux_o == 0, "R10 reset regs", {acc_o, aux_o}, 0);
    chk({cy_o, ov_o, par_o, done_o, busy_o} == 5'b0, "R10 reset flags",
        {cy_o, ov_o, par_o, done_o, busy_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R10 idle after reset", {busy_o, done_o}, 0);
    // directed boundaries around the multiply overflow edge
    do_op(1'b0, 8'd15, 8'd17, 0);
    do_op(1'b0, 8'd16, 8'd16, 0);
    do_op(1'b0, 8'hff, 8'hff, 0);
    do_op(1'b1, 8'hff, 8'h01, 0);
    do_op(1'b1, 8'h07, 8'h00, 0);
    do_op(1'b1, 8'h00, 8'h00, 2);
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 18; k++) begin
        logic [7:0] b;
        int ign;
        b = (k == 16) ? 8'h00 : (k == 17) ? 8'hff : 8'((k * 37 + a * 11) & 255);
        ign = ((a + k) % 5 == 0) ? 1 : ((a + k) % 5 == 1) ? 2 : 0;
        do_op(1'b0, 8'(a), b, ign);
        do_op(1'b1, 8'(a), b, ign);
      end
    end
    summary();
  end
endmodule